// File: doc/BRIEF.md
# Converter result serial port

This block moves each finished conversion word from a converter core to a host over one serial data line that can float. The core hands over a parallel word together with a one-cycle "new result" strobe. The port holds that word and pulls an active-low ready flag low once the word can be read. It then shifts the word out, most significant bit first, while the host holds an active-low select low.

A mode input picks who supplies the serial clock. In host-clocked mode the host drives the clock, and the port moves to the next bit on each falling edge. In self-clocked mode the port makes its own clock from the master clock: a short high phase and a low phase three times as long. In this mode it drives that clock out on a second line that can float.

Select and the host clock are sampled through a synchronizer on the master clock. Right after a new word is loaded, the ready flag is held high for a short update window. A select seen during that window is not acted on until the window closes. A word that arrives during a read waits until the read ends, and only the most recent such word is kept. If select is released part way through a word, the port finishes the bit on the line before it lets go of the line.

Top module: `result_serial_port`

## Requirements
- R1: Each complete read shifts out exactly WORD_W (16) bits on `ser_dout`, most significant bit first and bit 0 last, in both clock modes. After the final bit the data enable drops.
- R2: In host-clocked mode (`host_clk_mode` = 1), `ser_dout` moves to the next bit only after a falling edge of `ser_clk_in`. It holds its value for the whole high phase of `ser_clk_in`.
- R3: In self-clocked mode (`host_clk_mode` = 0), `ser_dout_en` goes high on the third master clock rising edge after `sel_n` is seen low, and not before.
- R4: In self-clocked mode, `ser_clk_out` is low for CLK_LO_CYC (3) master cycles and high for CLK_HI_CYC (1) cycle per bit. `ser_dout` changes only on the edge where `ser_clk_out` falls. While `ser_clk_en` is low, `ser_clk_out` is held low.
- R5: After a word is loaded, `word_ready_n` stays high for HOLD_CYC (4) cycles and then goes low. It stays low for the whole transfer and returns high on the edge that ends the last bit of a complete read.
- R6: While `word_ready_n` is high in the update window, a low `sel_n` starts no transfer. A read that starts after the window shifts out the newly loaded word.
- R7: A result strobe during a transfer does not disturb the word being shifted. The pending word is loaded after the transfer ends, and if several arrive, the last one wins.
- R8: If `sel_n` goes high part way through a word, the outputs keep driving until the current bit ends at the next serial clock falling edge, and then both enables drop. The word stays unread (`word_ready_n` low), and the next read starts again at the most significant bit.
- R9: With no unread word, a low `sel_n` leaves `ser_dout_en` low.
- R10: While `rst` is high, and on the cycle after it, both enables are low and `word_ready_n` is high. Reset also ends any transfer in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| host_clk_mode | input | 1 | 1: host drives the serial clock; 0: port generates it |
| result_word | input | WORD_W | Parallel result from the converter core |
| result_strobe | input | 1 | One-cycle pulse marking a new result |
| sel_n | input | 1 | Active-low select from the host, asynchronous |
| ser_clk_in | input | 1 | Host serial clock (host-clocked mode), asynchronous |
| ser_dout | output | 1 | Serial data bit |
| ser_dout_en | output | 1 | Drive enable for the data line's tri-state buffer |
| ser_clk_out | output | 1 | Generated serial clock (self-clocked mode) |
| ser_clk_en | output | 1 | Drive enable for the generated clock's buffer |
| word_ready_n | output | 1 | Active-low: an unread word is ready |

## Verification
The bench uses the default parameters: a 16-bit word, a two-stage synchronizer, a four-cycle update window and a 3:1 generated clock. With these values the exact enable latency and every low and high phase length can be counted cycle by cycle. The short window also lets a select and a strobe given in the same cycle land inside it. A 16-bit word gives room to start injected results and deselects at chosen bit positions in both clock modes.

// File: rtl/rsp_pkg.sv
package rsp_pkg;
  typedef enum logic [0:0] {
    SH_IDLE = 1'b0,
    SH_RUN  = 1'b1
  } sh_state_t;
endpackage

// File: rtl/rsp_sync.sv
module rsp_sync #(
  parameter int            STAGES = 2,
  parameter int            W      = 1,
  parameter logic [W-1:0]  INIT   = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= INIT;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/rsp_result_hold.sv
module rsp_result_hold #(
  parameter int WORD_W   = 16,
  parameter int HOLD_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe,
  input  logic [WORD_W-1:0] word_in,
  input  logic              busy,
  input  logic              consume,
  output logic              load_go,
  output logic [WORD_W-1:0] out_word,
  output logic              ready_n
);
  localparam int CW = $clog2(HOLD_CYC + 1);

  logic [CW-1:0]     win_cnt, win_nx;
  logic              unread, unread_nx;
  logic [WORD_W-1:0] pend_word;
  logic              pend_valid;

  // a new word may only enter the output register between transfers
  assign load_go = !busy && (strobe || pend_valid);

  always_comb begin
    unread_nx = unread;
    win_nx    = win_cnt;
    if (load_go) begin
      unread_nx = 1'b1;
      win_nx    = CW'(HOLD_CYC);
    end else begin
      if (consume) unread_nx = 1'b0;
      if (win_cnt != '0) win_nx = win_cnt - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_cnt    <= '0;
      unread     <= 1'b0;
      pend_word  <= '0;
      pend_valid <= 1'b0;
      out_word   <= '0;
      ready_n    <= 1'b1;
    end else begin
      win_cnt <= win_nx;
      unread  <= unread_nx;
      ready_n <= !(unread_nx && (win_nx == '0));
      if (load_go) begin
        out_word   <= strobe ? word_in : pend_word;
        pend_valid <= 1'b0;
      end else if (strobe) begin
        pend_word  <= word_in;
        pend_valid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rsp_clk_gen.sv
module rsp_clk_gen #(
  parameter int HI_CYC = 1,
  parameter int LO_CYC = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic lvl,
  output logic fall
);
  localparam int MAXC = (HI_CYC > LO_CYC) ? HI_CYC : LO_CYC;
  localparam int PW   = (MAXC < 2) ? 1 : $clog2(MAXC);

  logic [PW-1:0] cnt;

  // last high cycle: the level drops at the coming edge
  assign fall = run && lvl && (cnt == PW'(HI_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      lvl <= 1'b0;
      cnt <= '0;
    end else if (!lvl) begin
      if (cnt == PW'(LO_CYC - 1)) begin
        lvl <= 1'b1;
        cnt <= '0;
      end else begin
        cnt <= cnt + PW'(1);
      end
    end else begin
      if (cnt == PW'(HI_CYC - 1)) begin
        lvl <= 1'b0;
        cnt <= '0;
      end else begin
        cnt <= cnt + PW'(1);
      end
    end
  end
endmodule

// File: rtl/rsp_shifter.sv
module rsp_shifter
  import rsp_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_low,
  input  logic              host_mode,
  input  logic              host_fall,
  input  logic              gen_fall,
  input  logic              ready_n,
  input  logic              load_go,
  input  logic [WORD_W-1:0] word,
  output logic              dout,
  output logic              dout_en,
  output logic              clk_en,
  output logic              busy,
  output logic              consume,
  output logic              self_run
);
  localparam int IW = $clog2(WORD_W);

  sh_state_t         st;
  logic [WORD_W-1:0] sreg;
  logic [IW-1:0]     left;
  logic              mode_q;
  logic              quit;
  logic              start, bit_end;

  assign start    = (st == SH_IDLE) && sel_low && !ready_n && !load_go;
  assign bit_end  = (st == SH_RUN) && (mode_q ? host_fall : gen_fall);
  assign busy     = (st == SH_RUN);
  assign consume  = bit_end && (left == '0);
  assign self_run = (st == SH_RUN) && !mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= SH_IDLE;
      sreg    <= '0;
      left    <= '0;
      mode_q  <= 1'b0;
      quit    <= 1'b0;
      dout    <= 1'b0;
      dout_en <= 1'b0;
      clk_en  <= 1'b0;
    end else begin
      case (st)
        SH_IDLE: begin
          if (start) begin
            st      <= SH_RUN;
            mode_q  <= host_mode;
            sreg    <= word << 1;
            dout    <= word[WORD_W-1];
            dout_en <= 1'b1;
            clk_en  <= !host_mode;
            left    <= IW'(WORD_W - 1);
            quit    <= 1'b0;
          end
        end
        SH_RUN: begin
          if (!sel_low) quit <= 1'b1;
          if (bit_end) begin
            if ((left == '0) || quit || !sel_low) begin
              st      <= SH_IDLE;
              dout    <= 1'b0;
              dout_en <= 1'b0;
              clk_en  <= 1'b0;
            end else begin
              dout <= sreg[WORD_W-1];
              sreg <= sreg << 1;
              left <= left - IW'(1);
            end
          end
        end
        default: st <= SH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/result_serial_port.sv
module result_serial_port #(
  parameter int WORD_W      = 16,
  parameter int HOLD_CYC    = 4,
  parameter int SYNC_STAGES = 2,
  parameter int CLK_HI_CYC  = 1,
  parameter int CLK_LO_CYC  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_clk_mode,
  input  logic [WORD_W-1:0] result_word,
  input  logic              result_strobe,
  input  logic              sel_n,
  input  logic              ser_clk_in,
  output logic              ser_dout,
  output logic              ser_dout_en,
  output logic              ser_clk_out,
  output logic              ser_clk_en,
  output logic              word_ready_n
);
  logic [1:0]        sync_q;
  logic              sel_s, hclk_s, hclk_prev, host_fall;
  logic              busy, consume, load_go, self_run, gen_fall;
  logic [WORD_W-1:0] out_word;

  rsp_sync #(.STAGES(SYNC_STAGES), .W(2), .INIT(2'b01)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({ser_clk_in, sel_n}),
    .q   (sync_q)
  );
  assign sel_s  = sync_q[0];
  assign hclk_s = sync_q[1];

  always_ff @(posedge clk) begin
    if (rst) hclk_prev <= 1'b0;
    else     hclk_prev <= hclk_s;
  end
  assign host_fall = hclk_prev && !hclk_s;

  rsp_result_hold #(.WORD_W(WORD_W), .HOLD_CYC(HOLD_CYC)) u_hold (
    .clk      (clk),
    .rst      (rst),
    .strobe   (result_strobe),
    .word_in  (result_word),
    .busy     (busy),
    .consume  (consume),
    .load_go  (load_go),
    .out_word (out_word),
    .ready_n  (word_ready_n)
  );

  rsp_clk_gen #(.HI_CYC(CLK_HI_CYC), .LO_CYC(CLK_LO_CYC)) u_gen (
    .clk  (clk),
    .rst  (rst),
    .run  (self_run),
    .lvl  (ser_clk_out),
    .fall (gen_fall)
  );

  rsp_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .sel_low   (!sel_s),
    .host_mode (host_clk_mode),
    .host_fall (host_fall),
    .gen_fall  (gen_fall),
    .ready_n   (word_ready_n),
    .load_go   (load_go),
    .word      (out_word),
    .dout      (ser_dout),
    .dout_en   (ser_dout_en),
    .clk_en    (ser_clk_en),
    .busy      (busy),
    .consume   (consume),
    .self_run  (self_run)
  );
endmodule

// File: rtl/rsp_checker.sv
module rsp_checker #(
  parameter int HI_CYC = 1
) (
  input logic clk,
  input logic rst,
  input logic ser_dout,
  input logic ser_dout_en,
  input logic ser_clk_out,
  input logic ser_clk_en,
  input logic word_ready_n
);
  AST_RESET_FLOAT: assert property (@(posedge clk) $past(rst) |-> (!ser_dout_en && !ser_clk_en && word_ready_n)); // R10
  AST_READY_LOW_WHILE_DRIVING: assert property (@(posedge clk) disable iff (rst) ser_dout_en |-> !word_ready_n); // R5
  AST_CLK_EN_NEEDS_DATA_EN: assert property (@(posedge clk) disable iff (rst) ser_clk_en |-> ser_dout_en); // R4
  AST_CLK_PARKED_LOW: assert property (@(posedge clk) disable iff (rst) !ser_clk_en |-> !ser_clk_out); // R4
  AST_DATA_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (rst) (ser_clk_en && $past(ser_clk_en) && !$stable(ser_dout)) |-> $fell(ser_clk_out)); // R4

  if (HI_CYC == 1) begin : g_one_high
    AST_SINGLE_HIGH_CYCLE: assert property (@(posedge clk) disable iff (rst) $rose(ser_clk_out) |=> !ser_clk_out); // R4
  end
endmodule

bind result_serial_port rsp_checker #(.HI_CYC(CLK_HI_CYC)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .ser_dout     (ser_dout),
  .ser_dout_en  (ser_dout_en),
  .ser_clk_out  (ser_clk_out),
  .ser_clk_en   (ser_clk_en),
  .word_ready_n (word_ready_n)
);

// File: tb/result_serial_port_test.sv
module result_serial_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int HP = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_clk_mode = 1'b1;
  logic [15:0] result_word = '0;
  logic        result_strobe = 1'b0;
  logic        sel_n = 1'b1;
  logic        ser_clk_in = 1'b0;
  logic        ser_dout, ser_dout_en, ser_clk_out, ser_clk_en, word_ready_n;

  int n_checks = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  result_serial_port uut (
    .clk(clk), .rst(rst), .host_clk_mode(host_clk_mode),
    .result_word(result_word), .result_strobe(result_strobe),
    .sel_n(sel_n), .ser_clk_in(ser_clk_in),
    .ser_dout(ser_dout), .ser_dout_en(ser_dout_en),
    .ser_clk_out(ser_clk_out), .ser_clk_en(ser_clk_en),
    .word_ready_n(word_ready_n)
  );

  // {host clocked?, word}
  localparam logic [16:0] VEC [6] = '{
    17'h1_A5C3, 17'h0_A5C3, 17'h1_8001, 17'h0_7FFE, 17'h1_FFFF, 17'h0_0000
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic post_word(input logic [15:0] w);
    @(negedge clk);
    result_word   = w;
    result_strobe = 1'b1;
    @(negedge clk);
    result_strobe = 1'b0;
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 60 && word_ready_n; i++) @(negedge clk);
    check("R5 ready low after load", word_ready_n, 1'b0);
  endtask

  task automatic host_read(output logic [15:0] got, input int stop_after,
                           input logic inject, input logic [15:0] w1, input logic [15:0] w2);
    logic b;
    got = '0;
    host_clk_mode = 1'b1;
    ser_clk_in = 1'b0;
    @(negedge clk);
    sel_n = 1'b0;
    repeat (6) @(negedge clk);
    check("R1 data driven once selected", ser_dout_en, 1'b1);
    check("R2 no generated clock in host mode", ser_clk_en, 1'b0);
    for (int i = 0; i < 16; i++) begin
      if (i == stop_after) begin
        ser_clk_in = 1'b1;
        repeat (HP) @(negedge clk);
        sel_n = 1'b1;
        repeat (6) @(negedge clk);
        check("R8 current bit still driven", ser_dout_en, 1'b1);
        ser_clk_in = 1'b0;
        repeat (HP) @(negedge clk);
        check("R8 floats after bit end", ser_dout_en, 1'b0);
        check("R8 word stays unread", word_ready_n, 1'b0);
        return;
      end
      b = ser_dout;
      got = {got[14:0], b};
      ser_clk_in = 1'b1;
      repeat (HP) @(negedge clk);
      if (inject && i == 4) post_word(w1);
      if (inject && i == 9) post_word(w2);
      if (inject && i == 10) check("R7 ready held during read", word_ready_n, 1'b0);
      check("R2 bit stable in high phase", ser_dout, b);
      ser_clk_in = 1'b0;
      repeat (HP) @(negedge clk);
    end
    check("R1 float after bit 0", ser_dout_en, 1'b0);
    if (!inject) check("R5 ready high after full read", word_ready_n, 1'b1);
    sel_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic self_read(output logic [15:0] got, input int stop_after);
    int   rises, lo, hi;
    logic prev, cur;
    got = '0;
    rises = 0;
    host_clk_mode = 1'b0;
    @(negedge clk);
    sel_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R3 not yet driving after two edges", ser_dout_en, 1'b0);
    @(negedge clk);
    check("R3 driving on third edge", ser_dout_en, 1'b1);
    check("R4 clock enabled", ser_clk_en, 1'b1);
    lo = 1;
    hi = 0;
    prev = ser_clk_out;
    for (int c = 0; c < 400; c++) begin
      @(negedge clk);
      if (!ser_dout_en) break;
      cur = ser_clk_out;
      if (cur && !prev) begin
        check("R4 low phase length", lo, 3);
        got = {got[14:0], ser_dout};
        rises++;
        hi = 1;
      end else if (cur) begin
        hi++;
      end else if (prev) begin
        check("R4 high phase length", hi, 1);
        lo = 1;
      end else begin
        lo++;
      end
      prev = cur;
      if (stop_after > 0 && rises == stop_after) break;
    end
    if (stop_after == 0) begin
      check("R1 sixteen clock pulses", rises, 16);
      check("R5 ready high after full read", word_ready_n, 1'b1);
      repeat (6) @(negedge clk);
      check("R9 no restart without new word", ser_dout_en, 1'b0);
      sel_n = 1'b1;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] got;
    repeat (3) @(negedge clk);
    check("R10 data enable low in reset", ser_dout_en, 1'b0);
    check("R10 clock enable low in reset", ser_clk_en, 1'b0);
    check("R10 ready high in reset", word_ready_n, 1'b1);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    check("R9 idle with no word", ser_dout_en, 1'b0);

    // table walk
    for (int v = 0; v < 6; v++) begin
      post_word(VEC[v][15:0]);
      wait_ready();
      if (VEC[v][16]) host_read(got, -1, 1'b0, 16'h0, 16'h0);
      else            self_read(got, 0);
      check("R1 word shifted MSB first", got, VEC[v][15:0]);
    end

    // R5 window timing: strobe sampled at edge k
    @(negedge clk);
    result_word = 16'h1234;
    result_strobe = 1'b1;
    @(negedge clk);
    result_strobe = 1'b0;
    repeat (3) @(negedge clk);
    check("R5 ready high through window", word_ready_n, 1'b1);
    @(negedge clk);
    check("R5 ready low after window", word_ready_n, 1'b0);
    host_read(got, -1, 1'b0, 16'h0, 16'h0);
    check("R5 windowed word read", got, 16'h1234);

    // R6 select during update window
    post_word(16'hAAAA);
    wait_ready();
    host_clk_mode = 1'b1;
    @(negedge clk);
    result_word = 16'h5A5A;
    result_strobe = 1'b1;
    sel_n = 1'b0;
    @(negedge clk);
    result_strobe = 1'b0;
    repeat (3) @(negedge clk);
    check("R6 select ignored in window", ser_dout_en, 1'b0);
    host_read(got, -1, 1'b0, 16'h0, 16'h0);
    check("R6 new word delivered", got, 16'h5A5A);

    // R7 results arriving mid-read
    post_word(16'hC3C3);
    wait_ready();
    host_read(got, -1, 1'b1, 16'h1111, 16'hE00E);
    check("R7 in-flight word intact", got, 16'hC3C3);
    wait_ready();
    host_read(got, -1, 1'b0, 16'h0, 16'h0);
    check("R7 latest pending word wins", got, 16'hE00E);

    // R8 host-mode abort and restart
    post_word(16'hF0A5);
    wait_ready();
    host_read(got, 5, 1'b0, 16'h0, 16'h0);
    host_read(got, -1, 1'b0, 16'h0, 16'h0);
    check("R8 restart from MSB host", got, 16'hF0A5);

    // R8 self-mode abort and restart
    post_word(16'h3C96);
    wait_ready();
    self_read(got, 4);
    sel_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R8 self bit still driven", ser_dout_en, 1'b1);
    for (int i = 0; i < 40 && ser_dout_en; i++) @(negedge clk);
    check("R8 self floats", ser_dout_en, 1'b0);
    check("R8 clock released", ser_clk_en, 1'b0);
    check("R8 clock ended low", ser_clk_out, 1'b0);
    check("R8 self word unread", word_ready_n, 1'b0);
    self_read(got, 0);
    check("R8 restart from MSB self", got, 16'h3C96);

    // R10 reset during a transfer
    post_word(16'h6789);
    wait_ready();
    host_clk_mode = 1'b0;
    @(negedge clk);
    sel_n = 1'b0;
    repeat (8) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    sel_n = 1'b1;
    check("R10 reset floats data", ser_dout_en, 1'b0);
    check("R10 reset floats clock", ser_clk_en, 1'b0);
    check("R10 reset raises ready", word_ready_n, 1'b1);
    repeat (8) @(negedge clk);
    check("R10 cleared word not offered", word_ready_n, 1'b1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule